// File: doc/BRIEF.md
# LVDS 7:1 Pixel Serializer

This block turns one parallel pixel into seven serial time slots on up to four data lanes, plus a clock lane. Each pixel carries eight-bit red, green and blue components together with horizontal sync, vertical sync and data enable. The block runs entirely on the fast slot clock, which is seven times the pixel rate. It asks for a new pixel by raising `pix_take` for one slot cycle in every seven. The pixel and the mapping select present during that cycle are captured at the clock edge that ends it.

Three bit-to-slot mappings can be chosen at run time. The first is an 18-bit mapping on three lanes. The second is a 24-bit mapping in which lanes 0 to 2 carry the six upper bits of each colour and lane 3 carries the two low bits. The third is a 24-bit mapping in which lanes 0 to 2 are identical to the 18-bit mapping and lane 3 carries the two upper bits. The clock lane repeats a fixed seven-slot frame so that the receiver can locate slot 0.

The outputs are single-ended lane bits, registered at the slot clock. Differential drivers, fast-clock generation and double-rate output cells belong to the surrounding logic. Reset is asserted asynchronously through `rst_n`, and its release is synchronised over two slot-clock edges.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst_n` is low, and for the two slot-clock edges after it rises, `lane_o`, `lane_en_o` and `pix_take` are all 0 and `clk_lane_o` is 1.
- R2: After reset, `pix_take` is high for exactly one cycle in every seven. The inputs and `map_sel` are captured at the edge that ends a `pix_take` cycle. Slot 0 of that pixel appears on the outputs in the following cycle, and slots 1 to 6 follow in the next six cycles.
- R3: For every pixel, the clock lane drives 1,1,0,0,0,1,1 in slots 0 to 6.
- R4: With `map_sel`=0, slots 0..6 carry: lane 0 = G0,R5,R4,R3,R2,R1,R0; lane 1 = B1,B0,G5,G4,G3,G2,G1; lane 2 = DE,VS,HS,B5,B4,B3,B2.
- R5: With `map_sel`=0 or 3, lane 3 stays 0 and colour bits 7 and 6 have no effect on any output. `lane_en_o` is 4'b0111 for these values and 4'b1111 for `map_sel`=1 or 2.
- R6: With `map_sel`=1, lanes 0 to 2 follow the R4 pattern with every colour bit index raised by two. Lane 0 = G2,R7..R2; lane 1 = B3,B2,G7..G3; lane 2 = DE,VS,HS,B7..B4.
- R7: With `map_sel`=1, lane 3 carries 0,B1,B0,G1,G0,R1,R0 in slots 0..6.
- R8: With `map_sel`=2, lanes 0 to 2 carry exactly the R4 pattern.
- R9: With `map_sel`=2, lane 3 carries 0,B7,B6,G7,G6,R7,R6 in slots 0..6.
- R10: The three control slots on lane 2 carry data enable in slot 0, vertical sync in slot 1 and horizontal sync in slot 2. Slot 0 of lane 3 is always 0.
- R11: Changes of `map_sel` or of the pixel inputs outside a `pix_take` cycle have no effect on the pixel being sent, and `lane_en_o` changes only at a capture edge.
- R12: `map_sel`=3 behaves exactly like `map_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 2 | Mapping: 0 18-bit, 1 24-bit low bits on lane 3, 2 24-bit high bits on lane 3, 3 as 0 |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| pix_take | output | 1 | High in the cycle whose closing edge captures the inputs |
| lane_o | output | 4 | Data lane bits for the current slot |
| clk_lane_o | output | 1 | Clock lane bit for the current slot |
| lane_en_o | output | 4 | Lanes in use by the current mapping |

## Verification
A capture happens at the edge that ends a `pix_take` cycle. The first slot of that pixel is visible from that edge on, and slot k is due k cycles later. `lane_en_o` changes at the same edge as slot 0. The first `pix_take` follows two edges after reset release. The bench model counts these delays itself from its own reset tracking. It compares every output half a period after each rising edge, so that each compare sees exactly one registered update. The bench also changes the inputs and `map_sel` in the cycles between captures, which shows whether anything other than the capture edge reaches the outputs.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOTS   = 7;
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;
  localparam int SLOT_W  = $clog2(SLOTS);

  typedef logic [SLOTS-1:0] word_t;

  typedef enum logic [1:0] {
    MAP_N18 = 2'd0,
    MAP_J24 = 2'd1,
    MAP_V24 = 2'd2,
    MAP_ALT = 2'd3
  } map_e;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pix_t;

  // bit k is the value of slot k
  localparam word_t CLK_FRAME = 7'b1100011;
endpackage

// File: rtl/lvds_slot_mapper.sv
module lvds_slot_mapper
  import lvds_ser_pkg::*;
(
  input  pix_t                  pix_i,
  input  map_e                  map_i,
  output word_t [LANES-1:0]     words_o,
  output logic  [LANES-1:0]     en_o
);
  function automatic word_t slots7(input logic s0, input logic s1, input logic s2,
                                   input logic s3, input logic s4, input logic s5,
                                   input logic s6);
    return {s6, s5, s4, s3, s2, s1, s0};
  endfunction

  logic [5:0] r6, g6, b6;
  logic       upper;

  always_comb begin
    upper = (map_i == MAP_J24);
    r6 = upper ? pix_i.r[7:2] : pix_i.r[5:0];
    g6 = upper ? pix_i.g[7:2] : pix_i.g[5:0];
    b6 = upper ? pix_i.b[7:2] : pix_i.b[5:0];

    words_o[0] = slots7(g6[0], r6[5], r6[4], r6[3], r6[2], r6[1], r6[0]);
    words_o[1] = slots7(b6[1], b6[0], g6[5], g6[4], g6[3], g6[2], g6[1]);
    words_o[2] = slots7(pix_i.de, pix_i.vs, pix_i.hs, b6[5], b6[4], b6[3], b6[2]);

    unique case (map_i)
      MAP_J24: begin
        words_o[3] = slots7(1'b0, pix_i.b[1], pix_i.b[0], pix_i.g[1], pix_i.g[0],
                            pix_i.r[1], pix_i.r[0]);
        en_o       = 4'b1111;
      end
      MAP_V24: begin
        words_o[3] = slots7(1'b0, pix_i.b[7], pix_i.b[6], pix_i.g[7], pix_i.g[6],
                            pix_i.r[7], pix_i.r[6]);
        en_o       = 4'b1111;
      end
      default: begin
        words_o[3] = '0;
        en_o       = 4'b0111;
      end
    endcase
  end
endmodule

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer
  import lvds_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic              load_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign load_o = (cnt_q == '0);
  assign slot_o = cnt_q;
endmodule

// File: rtl/lvds_lane_shift.sv
module lvds_lane_shift
  import lvds_ser_pkg::*;
#(
  parameter logic RST_BIT = 1'b0
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  word_t word_i,
  output logic  bit_o
);
  word_t sh_q, sh_d;
  logic  bit_q, bit_d;

  always_comb begin
    if (load_i) begin
      bit_d = word_i[0];
      sh_d  = word_i >> 1;
    end else begin
      bit_d = sh_q[0];
      sh_d  = sh_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= RST_BIT;
      sh_q  <= '0;
    end else begin
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           map_sel,
  input  logic [COLOR_W-1:0]   red,
  input  logic [COLOR_W-1:0]   green,
  input  logic [COLOR_W-1:0]   blue,
  input  logic                 hsync,
  input  logic                 vsync,
  input  logic                 de,
  output logic                 pix_take,
  output logic [LANES-1:0]     lane_o,
  output logic                 clk_lane_o,
  output logic [LANES-1:0]     lane_en_o
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              load;
  logic [SLOT_W-1:0] slot;
  pix_t              pix;
  word_t [LANES-1:0] words;
  logic  [LANES-1:0] en_d, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  lvds_slot_timer u_timer (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load_o (load),
    .slot_o (slot)
  );

  assign pix = '{r: red, g: green, b: blue, hs: hsync, vs: vsync, de: de};

  lvds_slot_mapper u_map (
    .pix_i   (pix),
    .map_i   (map_e'(map_sel)),
    .words_o (words),
    .en_o    (en_d)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lvds_lane_shift #(.RST_BIT(1'b0)) u_sh (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .load_i (load),
      .word_i (words[l]),
      .bit_o  (lane_o[l])
    );
  end

  lvds_lane_shift #(.RST_BIT(CLK_FRAME[0])) u_clk_sh (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load_i (load),
    .word_i (CLK_FRAME),
    .bit_o  (clk_lane_o)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) en_q <= '0;
    else if (load)   en_q <= en_d;
  end

  assign lane_en_o = en_q;
  assign pix_take  = core_rst_n & load;
endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       de,
  input logic       pix_take,
  input logic [3:0] lane_o,
  input logic       clk_lane_o,
  input logic [3:0] lane_en_o
);
  assert_take_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take |=> !pix_take);

  assert_clk_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_take) |-> clk_lane_o);

  assert_clk_slot2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_take, 3) |-> !clk_lane_o);

  assert_idle_lane3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en_o[3] |-> !lane_o[3]);

  assert_de_slot0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_take) |-> (lane_o[2] == $past(de)));

  assert_lane3_slot0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_take) |-> !lane_o[3]);

  assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_take) |-> $stable(lane_en_o));
endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .de         (de),
  .pix_take   (pix_take),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .lane_en_o  (lane_en_o)
);

// File: tb/sim_lvds_pixel_serializer.sv
module sim_lvds_pixel_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] map_sel = 2'd0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0;
  logic       pix_take, clk_lane_o;
  logic [3:0] lane_o, lane_en_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lvds_pixel_serializer u0 (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
    .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .de(de),
    .pix_take(pix_take), .lane_o(lane_o),
    .clk_lane_o(clk_lane_o), .lane_en_o(lane_en_o)
  );

  // Reference: bit in slot s of lane l for mapping m
  function automatic logic ref_bit(int m, int l, int s, logic [7:0] r, logic [7:0] g,
                                   logic [7:0] b, logic h, logic v, logic d);
    logic t[0:6];
    int   o;
    o = (m == 1) ? 2 : 0;
    case (l)
      0: t = '{g[o], r[o+5], r[o+4], r[o+3], r[o+2], r[o+1], r[o]};
      1: t = '{b[o+1], b[o], g[o+5], g[o+4], g[o+3], g[o+2], g[o+1]};
      2: t = '{d, v, h, b[o+5], b[o+4], b[o+3], b[o+2]};
      default: begin
        if (m == 1)      t = '{1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
        else if (m == 2) t = '{1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
        else             t = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      end
    endcase
    return t[s];
  endfunction

  // Behavioural model state
  int         m_sync = 0;
  int         m_slot = 0;
  int         m_mode = 0;
  logic [7:0] c_r, c_g, c_b;
  logic       c_h, c_v, c_d;
  logic [3:0] e_lane = '0;
  logic       e_clk = 1'b1;
  logic [3:0] e_en = '0;
  logic       e_take = 1'b0;
  bit         in_reset = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_slot = 0; in_reset = 1'b1;
      e_lane = '0; e_clk = 1'b1; e_en = '0; e_take = 1'b0;
    end else if (m_sync < 2) begin
      m_sync++;
      e_take = (m_sync == 2);
    end else begin
      in_reset = 1'b0;
      if (m_slot == 0) begin
        m_mode = int'(map_sel);
        c_r = red; c_g = green; c_b = blue; c_h = hsync; c_v = vsync; c_d = de;
        e_en = (m_mode == 1 || m_mode == 2) ? 4'b1111 : 4'b0111;
      end
      for (int l = 0; l < 4; l++)
        e_lane[l] = ref_bit(m_mode, l, m_slot, c_r, c_g, c_b, c_h, c_v, c_d);
      e_clk  = (m_slot < 2 || m_slot > 4);
      m_slot = (m_slot + 1) % 7;
      e_take = (m_slot == 0);
    end
  end

  function automatic string lane_tag(int l);
    if (in_reset)    return "R1";
    if (m_mode == 1) return (l < 3) ? "R6" : "R7";
    if (m_mode == 2) return (l < 3) ? "R8" : "R9";
    if (m_mode == 3) return "R12";
    return (l < 3) ? "R4" : "R5";
  endfunction

  // Compare all outputs on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      for (int l = 0; l < 4; l++) begin
        compared++;
        if (lane_o[l] !== e_lane[l]) begin
          mismatched++;
          $display("FAIL %s lane %0d slot-count %0d: got %b expected %b",
                   lane_tag(l), l, m_slot, lane_o[l], e_lane[l]);
        end
      end
      compared++;
      if (clk_lane_o !== e_clk) begin
        mismatched++;
        $display("FAIL %s clock lane: got %b expected %b", in_reset ? "R1" : "R3",
                 clk_lane_o, e_clk);
      end
      compared++;
      if (lane_en_o !== e_en) begin
        mismatched++;
        $display("FAIL %s lane enable: got %b expected %b", in_reset ? "R1" : "R5",
                 lane_en_o, e_en);
      end
      compared++;
      if (pix_take !== e_take) begin
        mismatched++;
        $display("FAIL %s pix_take: got %b expected %b", in_reset ? "R1" : "R2",
                 pix_take, e_take);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Send one pixel; optionally disturb inputs after capture (R11)
  task automatic send_pix(input logic [1:0] m, input logic [7:0] r, input logic [7:0] g,
                          input logic [7:0] b, input logic h, input logic v,
                          input logic d, input bit disturb);
    do @(negedge clk); while (pix_take !== 1'b1);
    #1;
    map_sel = m; red = r; green = g; blue = b; hsync = h; vsync = v; de = d;
    if (disturb) begin
      @(negedge clk); #1;
      map_sel = ~m; red = ~r; green = ~g; blue = ~b; hsync = ~h; vsync = ~v; de = ~d;
      @(negedge clk); #1;
      map_sel = m + 2'd1; red = r ^ 8'h5A; blue = b ^ 8'hC3;
    end
  endtask

  initial begin
    // R1: outputs held at reset values for a few cycles
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      // R4 R6 R8 R12: walking ones through every colour bit
      for (int i = 0; i < 24; i++) begin
        logic [23:0] w;
        w = 24'd1 << i;
        send_pix(2'(m), w[23:16], w[15:8], w[7:0], i[0], i[1], i[2], 1'b0);
      end
      // R10: each control bit alone
      send_pix(2'(m), 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
      send_pix(2'(m), 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
      send_pix(2'(m), 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
      // R5 R7 R9: upper and lower bit pairs only
      send_pix(2'(m), 8'hC0, 8'hC0, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0);
      send_pix(2'(m), 8'h03, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0);
      send_pix(2'(m), 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
      // R11: disturbed inputs between captures
      for (int k = 0; k < 8; k++)
        send_pix(2'(m), 8'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    end
    // R2 R11: mapping changes pixel to pixel
    for (int k = 0; k < 16; k++)
      send_pix(2'(k % 4), 8'($urandom), 8'($urandom), 8'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), k[0]);
    // R1: reset asserted mid-pixel, then recovery
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    send_pix(2'd1, 8'hA5, 8'h3C, 8'h96, 1'b1, 1'b0, 1'b1, 1'b0);
    send_pix(2'd2, 8'h5A, 8'hC3, 8'h69, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule